// File: doc/BRIEF.md
# Dual-Channel Acquisition Buffer Controller

This block collects sample pairs from an in-phase and a quadrature converter, both taken at the same instant. Each 10-bit sample is sign-extended into its own 16-bit half, and the two halves form one 32-bit word. The words fill a 1 KB two-port buffer of 256 words. When the last word is written, the block raises an interrupt toward a local-bus DMA master. That master reads the buffer out through a second port and then acknowledges. After the acknowledge, capture continues from the first word.

The sample input is a valid strobe with no back-pressure, because a converter cannot be stalled. While the buffer waits for its acknowledge, the block cannot accept a sample. Any sample offered then is discarded and recorded in a sticky overflow flag. Start and stop are single-cycle host commands. The read port is a plain synchronous read with a latency of one cycle. Everything runs on one clock.

Top module: `acq_capture_top`

## Requirements
- R1: After reset, `irq_o` and `overflow_o` are 0, `rd_data_o` is 0, and the block is idle.
- R2: A word holds the in-phase sample, sign-extended from bit 9, in bits [15:0], and the quadrature sample, sign-extended the same way, in bits [31:16]. For example, I=10'h200 and Q=10'h1FF give 32'h01FF_FE00.
- R3: After a start, the k-th accepted sample is stored at buffer address k, beginning at address 0.
- R4: `irq_o` rises in the cycle after the 256th accepted sample is taken, and not earlier.
- R5: `irq_o` stays high until `irq_ack_i` is pulsed. After the acknowledge, writing resumes at address 0.
- R6: A sample offered while `irq_o` is high is dropped and leaves the buffer unchanged. It sets `overflow_o`, which stays set until the next start.
- R7: A stop ends writing from the next cycle. It raises no interrupt, and later samples are not stored.
- R8: Asserting `rd_en_i` returns the word at `rd_addr_i` on `rd_data_o` one cycle later. With `rd_en_i` low, `rd_data_o` holds its value.
- R9: Samples offered while idle are neither stored nor counted, and they do not set `overflow_o`.
- R10: A start issued part-way through a buffer restarts writing at address 0.
- R11: `irq_ack_i` has no effect while `irq_o` is low.
- R12: If stop and start arrive in the same cycle, stop takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for sampling and readout |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid_i | input | 1 | A sample pair is present this cycle |
| smp_i_i | input | 10 | In-phase sample, two's complement |
| smp_q_i | input | 10 | Quadrature sample, two's complement |
| start_i | input | 1 | Start pulse: restart at address 0 and clear overflow |
| stop_i | input | 1 | Stop pulse: halt writing |
| rd_en_i | input | 1 | Read strobe from the bus master |
| rd_addr_i | input | 8 | Word address to read |
| rd_data_o | output | 32 | Read data, one cycle after the strobe |
| irq_o | output | 1 | Buffer-full interrupt |
| irq_ack_i | input | 1 | Interrupt acknowledge pulse |
| overflow_o | output | 1 | Sticky flag: a sample was dropped |

## Verification
The assertions assume that `start_i`, `stop_i` and `irq_ack_i` are single-cycle pulses and that every input changes only between clock edges. They also assume that the reader never reads the address being written in the same cycle. The bench drives all inputs at the falling edge and issues each command for exactly one cycle. It reads the buffer only while writing is halted, or at addresses that were written earlier.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FULL = 2'd2
  } acq_state_e;
endpackage

// File: rtl/acq_pack.sv
// Sign-extends each channel sample into its own field of the packed word.
module acq_pack #(
  parameter int SAMPLE_W = 10,
  parameter int FIELD_W  = 16,
  parameter int NUM_CH   = 2
) (
  input  logic [NUM_CH*SAMPLE_W-1:0] samples_i,
  output logic [NUM_CH*FIELD_W-1:0]  word_o
);
  localparam int EXT_W = FIELD_W - SAMPLE_W;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [SAMPLE_W-1:0] smp;
    assign smp = samples_i[ch*SAMPLE_W +: SAMPLE_W];
    assign word_o[ch*FIELD_W +: FIELD_W] = {{EXT_W{smp[SAMPLE_W-1]}}, smp};
  end
endmodule

// File: rtl/acq_dpram.sv
// One write port, one registered read port, one clock.
module acq_dpram #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_o <= '0;
    else if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/acq_ctrl.sv
// Capture sequencing: write pointer, buffer-full handoff, overflow.
module acq_ctrl
  import acq_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          ack_i,
  input  logic          valid_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          irq_o,
  output logic          ovf_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  acq_state_e    state_q;
  logic [AW-1:0] ptr_q;
  logic          ovf_q;

  always_comb begin
    wr_en_o   = (state_q == ST_RUN) && valid_i;
    wr_addr_o = ptr_q;
    irq_o     = (state_q == ST_FULL);
    ovf_o     = ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      ovf_q   <= 1'b0;
    end else if (stop_i) begin
      // stop wins; a full buffer keeps waiting for its reader
      if (state_q == ST_RUN) state_q <= ST_IDLE;
    end else if (start_i) begin
      state_q <= ST_RUN;
      ptr_q   <= '0;
      ovf_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RUN: if (valid_i) begin
          ptr_q <= ptr_q + 1'b1;
          if (ptr_q == LAST) state_q <= ST_FULL;
        end
        ST_FULL: begin
          if (valid_i) ovf_q   <= 1'b1;
          if (ack_i)   state_q <= ST_RUN;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/acq_capture_top.sv
module acq_capture_top #(
  parameter int SAMPLE_W  = 10,
  parameter int FIELD_W   = 16,
  parameter int BUF_BYTES = 1024,
  localparam int NUM_CH   = 2,
  localparam int WORD_W   = NUM_CH * FIELD_W,
  localparam int DEPTH    = (BUF_BYTES * 8) / WORD_W,
  localparam int AW       = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid_i,
  input  logic [SAMPLE_W-1:0] smp_i_i,
  input  logic [SAMPLE_W-1:0] smp_q_i,
  input  logic                start_i,
  input  logic                stop_i,
  input  logic                rd_en_i,
  input  logic [AW-1:0]       rd_addr_i,
  output logic [WORD_W-1:0]   rd_data_o,
  output logic                irq_o,
  input  logic                irq_ack_i,
  output logic                overflow_o
);
  logic [WORD_W-1:0] packed_word;
  logic              wr_en;
  logic [AW-1:0]     wr_addr;

  acq_pack #(.SAMPLE_W(SAMPLE_W), .FIELD_W(FIELD_W), .NUM_CH(NUM_CH)) u_pack (
    .samples_i ({smp_q_i, smp_i_i}),
    .word_o    (packed_word)
  );

  acq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .ack_i     (irq_ack_i),
    .valid_i   (smp_valid_i),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .irq_o     (irq_o),
    .ovf_o     (overflow_o)
  );

  acq_dpram #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_ram (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (wr_en),
    .waddr_i (wr_addr),
    .wdata_i (packed_word),
    .re_i    (rd_en_i),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );
endmodule

// File: rtl/acq_capture_chk.sv
module acq_capture_chk #(
  parameter int AW     = 8,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              stop_i,
  input logic              ack_i,
  input logic              rd_en_i,
  input logic [WORD_W-1:0] rd_data_o,
  input logic              irq_o,
  input logic              ovf_o,
  input logic              wr_en,
  input logic [AW-1:0]     wr_addr
);
  p_step_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !start_i && !stop_i) |=> (wr_addr == $past(wr_addr) + 1'b1));

  p_irq_on_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(wr_en) && ($past(wr_addr) == {AW{1'b1}})));

  p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !ack_i && !start_i) |=> irq_o);

  p_no_write_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !wr_en);

  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !start_i) |=> ovf_o);

  p_stop_halts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !wr_en);

  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

bind acq_capture_top acq_capture_chk #(.AW(AW), .WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .stop_i    (stop_i),
  .ack_i     (irq_ack_i),
  .rd_en_i   (rd_en_i),
  .rd_data_o (rd_data_o),
  .irq_o     (irq_o),
  .ovf_o     (overflow_o),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr)
);

// File: tb/test_acq_capture_top.sv
`timescale 1ns/1ps
module test_acq_capture_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid_i = 1'b0;
  logic [9:0]  smp_i_i = '0;
  logic [9:0]  smp_q_i = '0;
  logic        start_i = 1'b0;
  logic        stop_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [7:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic        irq_o;
  logic        irq_ack_i = 1'b0;
  logic        overflow_o;

  always #2.5 clk = ~clk;

  acq_capture_top i_acq_capture_top (
    .clk(clk), .rst_n(rst_n), .smp_valid_i(smp_valid_i), .smp_i_i(smp_i_i),
    .smp_q_i(smp_q_i), .start_i(start_i), .stop_i(stop_i), .rd_en_i(rd_en_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .irq_o(irq_o),
    .irq_ack_i(irq_ack_i), .overflow_o(overflow_o)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model, written from the requirements
  logic [31:0] model_mem [256];
  int m_state = 0;   // 0 idle, 1 running, 2 full
  int m_ptr = 0;
  bit m_ovf = 1'b0;

  function automatic logic [31:0] pk(input logic [9:0] a, input logic [9:0] b);
    return {{6{b[9]}}, b, {6{a[9]}}, a};
  endfunction

  task automatic send(input logic [9:0] a, input logic [9:0] b);
    smp_valid_i = 1'b1; smp_i_i = a; smp_q_i = b;
    if (m_state == 1) begin
      model_mem[m_ptr] = pk(a, b);
      m_ptr++;
      if (m_ptr == 256) begin m_ptr = 0; m_state = 2; end
    end else if (m_state == 2) m_ovf = 1'b1;
    @(negedge clk);
    smp_valid_i = 1'b0;
  endtask

  task automatic do_start();
    start_i = 1'b1; m_state = 1; m_ptr = 0; m_ovf = 1'b0;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic do_stop();
    stop_i = 1'b1; if (m_state == 1) m_state = 0;
    @(negedge clk); stop_i = 1'b0;
  endtask

  task automatic do_ack();
    irq_ack_i = 1'b1; if (m_state == 2) m_state = 1;
    @(negedge clk); irq_ack_i = 1'b0;
  endtask

  // scoreboard: read driver pushes expectations, monitor pops them
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          rd_fired = 1'b0;

  task automatic rd(input logic [7:0] addr, input logic [31:0] exp, input string tag);
    rd_en_i = 1'b1; rd_addr_i = addr;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); rd_en_i = 1'b0;
  endtask

  always @(posedge clk) rd_fired <= rd_en_i;

  always @(negedge clk) begin
    if (rd_fired) begin
      if (exp_q.size() == 0) check(1'b0, "R8 unexpected read", rd_data_o, 32'h0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check(rd_data_o === e, t, rd_data_o, e);
      end
    end
  end

  task automatic drain();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(irq_o == 1'b0, "R1 irq after reset", {31'b0, irq_o}, 32'h0);
    check(overflow_o == 1'b0, "R1 overflow after reset", {31'b0, overflow_o}, 32'h0);
    check(rd_data_o == 32'h0, "R1 rd_data after reset", rd_data_o, 32'h0);

    // R9: idle samples ignored
    for (int i = 0; i < 5; i++) send(10'(i), 10'(i + 1));
    check(overflow_o == 1'b0, "R9 no overflow while idle", {31'b0, overflow_o}, 32'h0);

    // fill the buffer
    do_start();
    send(10'h200, 10'h1FF);
    for (int i = 1; i < 255; i++) send(10'(i * 37 + 5), 10'(1023 - i * 11));
    check(irq_o == 1'b0, "R4 no irq after 255 samples", {31'b0, irq_o}, 32'h0);
    send(10'h3FF, 10'h001);
    check(irq_o == 1'b1, "R4 irq after 256th sample", {31'b0, irq_o}, 32'h1);

    // R6: samples while full are dropped
    for (int i = 0; i < 3; i++) send(10'h155, 10'h2AA);
    check(overflow_o == 1'b1, "R6 overflow set", {31'b0, overflow_o}, 32'h1);
    check(irq_o == 1'b1, "R5 irq held without ack", {31'b0, irq_o}, 32'h1);

    rd(8'd0, 32'h01FF_FE00, "R2 sign-extended packing");
    rd(8'd255, 32'h0001_FFFF, "R2 negative in-phase field");
    for (int a = 0; a < 256; a++) rd(8'(a), model_mem[a], "R3/R6 buffer contents");
    drain();

    // R5: acknowledge resumes at address 0
    do_ack();
    check(irq_o == 1'b0, "R5 irq cleared by ack", {31'b0, irq_o}, 32'h0);
    check(overflow_o == 1'b1, "R6 overflow sticky across ack", {31'b0, overflow_o}, 32'h1);
    for (int i = 0; i < 10; i++) send(10'(i * 101), 10'(i * 59 + 300));
    do_stop();
    for (int a = 0; a < 11; a++) rd(8'(a), model_mem[a], "R5 resume at address 0");
    drain();

    // R7: stop halts writing
    for (int i = 0; i < 4; i++) send(10'h0AA, 10'h0BB);
    for (int a = 10; a < 14; a++) rd(8'(a), model_mem[a], "R7 no write after stop");
    drain();
    check(irq_o == 1'b0, "R7 no irq after stop", {31'b0, irq_o}, 32'h0);

    // R12: stop has priority over start
    start_i = 1'b1; stop_i = 1'b1;
    @(negedge clk); start_i = 1'b0; stop_i = 1'b0;
    send(10'h111, 10'h222);
    check(overflow_o == 1'b1, "R12 start ignored beside stop", {31'b0, overflow_o}, 32'h1);
    rd(8'd0, model_mem[0], "R12 nothing written");
    drain();

    // R10 / R11: restart mid-buffer, ack while running ignored
    do_start();
    check(overflow_o == 1'b0, "R6 overflow cleared by start", {31'b0, overflow_o}, 32'h0);
    for (int i = 0; i < 3; i++) send(10'(i + 700), 10'(i + 40));
    do_ack();
    for (int i = 0; i < 2; i++) send(10'(i + 800), 10'(i + 90));
    do_stop();
    for (int a = 0; a < 5; a++) rd(8'(a), model_mem[a], "R10/R11 restart and ack ignored");
    rd(8'd5, model_mem[5], "R11 address 5 untouched");
    drain();
    check(irq_o == 1'b0, "R11 ack gives no irq", {31'b0, irq_o}, 32'h0);

    // R8: read data holds while strobe is low
    rd(8'd1, model_mem[1], "R8 read");
    drain();
    held = rd_data_o;
    do_start();
    for (int i = 0; i < 3; i++) send(10'h3C3, 10'h0F0);
    check(rd_data_o == held, "R8 rd_data held", rd_data_o, held);
    do_stop();

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule